// File: doc/BRIEF.md
# Iterative Restoring Integer Divider

This block divides one integer operand by another over a fixed run of clock cycles and returns the quotient. It handles two operations, chosen by a 6-bit operation code: an unsigned divide and a signed divide. The signed divide truncates toward zero. One register holds the dividend as it shifts out and collects the quotient bits as they shift in. Each clock cycle of the run produces one quotient bit by a shift, a compare and a conditional subtract.

The signed case uses the same unsigned engine. Before the loop, both operands are replaced by their magnitudes. The sign of the result is the exclusive-or of the two operand sign bits, and the quotient is negated once in a final cycle when that sign is set. The remainder is used only inside the engine and is not returned. A zero divisor raises no error and gives a defined quotient.

The caller drives a one-cycle `start` with the operands and code while `busy` is low. It then waits for the one-cycle `done` pulse. `quotient` holds its value until the next `done`.

Top module: `seq_divider`

## Requirements
- R1: The operation is signed when `opx` equals 0x25. Every other code, 0x24 included, selects the unsigned operation. Example at W=8: 0xF0 / 0x02 under code 0x3F gives 0x78.
- R2: In the unsigned operation with a non-zero divisor, the quotient equals floor(a / b), with both operands read as unsigned W-bit values.
- R3: In the signed operation with a non-zero divisor, the quotient equals the two's-complement quotient truncated toward zero. It is negative exactly when the two operand sign bits differ and the magnitude quotient is non-zero.
- R4: The engine runs a restoring loop of exactly W iterations and yields one quotient bit per iteration. After every iteration with a non-zero divisor, the remainder it holds is below the divisor.
- R5: A zero divisor gives an all-ones magnitude quotient. In the unsigned case the result is all ones. In the signed case it is 1 when `a` is negative and all ones otherwise.
- R6: In the signed operation, the most negative value keeps its own bit pattern as its magnitude and counts as 2^(W-1). At W=8: 0x80/0xFF gives 0x80, 0x80/0x01 gives 0x80, and 0x80/0x02 gives 0xC0.
- R7: When `start` is accepted on a clock edge, `busy` is high for the next W+1 cycles (one load edge, W iterations, one sign fix-up). `done` rises at the (W+1)th edge after the accepting edge, and `busy` is low in that cycle.
- R8: `done` is high for exactly one cycle. `quotient` changes only on the edge that raises `done` and holds its value in between.
- R9: `start` is ignored while `busy` is high. Neither the running result nor its timing changes, and no second operation begins.
- R10: `start` is accepted in the cycle in which `done` is high, so operations can follow each other with no idle cycle.
- R11: After reset, `busy`, `done` and `quotient` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled while idle |
| opx | input | 6 | Operation code: 0x25 signed, other values unsigned |
| a | input | W | Dividend |
| b | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | W | Result of the last completed operation |

## Verification
Two events can fall in the same cycle: the completion of one division (`done` high, `busy` low) and the acceptance of the next `start`. The bench provokes this on every operation of its sweep by raising the next `start` in the exact cycle where it samples `done`. It then judges each result against a quotient worked out arithmetically for that operation, so a lost, late or corrupted back-to-back start shows up as a wrong quotient or as a missing `done` one period later. A second case raises `start` in the middle of a busy run and checks that the result and the `done` timing stay the same as without it.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

  localparam logic [5:0] OPX_UDIV = 6'h24;
  localparam logic [5:0] OPX_SDIV = 6'h25;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic         signed_op,
  input  logic [W-1:0] dividend_in,
  input  logic [W-1:0] divisor_in,
  output logic [W-1:0] dividend_mag,
  output logic [W-1:0] divisor_mag,
  output logic         negate_result
);
  // magnitude of a two's-complement value; the most negative value maps to itself
  function automatic logic [W-1:0] magnitude(input logic sgn, input logic [W-1:0] v);
    return (sgn && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  assign dividend_mag  = magnitude(signed_op, dividend_in);
  assign divisor_mag   = magnitude(signed_op, divisor_in);
  assign negate_result = signed_op & (dividend_in[W-1] ^ divisor_in[W-1]);
endmodule

// File: rtl/div_engine.sv
module div_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo_dvd,
  output logic [W-1:0] divisor_q,
  output logic         sub_taken
);
  logic [W-1:0] rem_q;
  logic [W:0]   rem_shift;
  logic [W:0]   rem_next;

  // one restoring iteration: shift the remainder in, compare, subtract
  function automatic logic [W:0] trial_sub(input logic [W:0] r, input logic [W-1:0] d);
    return r - {1'b0, d};
  endfunction

  assign rem_shift = {rem_q, quo_dvd[W-1]};
  assign sub_taken = (rem_shift >= {1'b0, divisor_q});
  assign rem_next  = sub_taken ? trial_sub(rem_shift, divisor_q) : rem_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q     <= '0;
      quo_dvd   <= '0;
      divisor_q <= '0;
    end else if (load) begin
      rem_q     <= '0;
      quo_dvd   <= dividend;
      divisor_q <= divisor;
    end else if (step) begin
      rem_q     <= rem_next[W-1:0];
      quo_dvd   <= {quo_dvd[W-2:0], sub_taken};
    end
  end

  // R4: the restoring loop never leaves a remainder at or above a non-zero divisor
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (divisor_q == '0) || (rem_q < divisor_q));
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic         negate,
  input  logic [W-1:0] magnitude_q,
  output logic [W-1:0] result
);
  function automatic logic [W-1:0] apply_sign(input logic neg, input logic [W-1:0] m);
    return neg ? (~m + 1'b1) : m;
  endfunction

  assign result = apply_sign(negate, magnitude_q);
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   opx,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int LW = $clog2(W + 2) + 1;
  localparam logic [CW-1:0] LAST_ITER = CW'(W - 1);

  div_state_e    state;
  logic [CW-1:0] iter_left;
  logic          sign_q;

  logic          accept;
  logic          iterate;
  logic          signed_op;
  logic [W-1:0]  dvd_mag, dvs_mag;
  logic          neg_now;
  logic [W-1:0]  quo_dvd, divisor_q, fixed_q;
  logic          sub_taken;

  assign signed_op = (opx == OPX_SDIV);
  assign accept    = start && (state == ST_IDLE);
  assign iterate   = (state == ST_RUN);
  assign busy      = (state != ST_IDLE);

  div_operand_prep #(.W(W)) u_prep (
    .signed_op    (signed_op),
    .dividend_in  (a),
    .divisor_in   (b),
    .dividend_mag (dvd_mag),
    .divisor_mag  (dvs_mag),
    .negate_result(neg_now)
  );

  div_engine #(.W(W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (iterate),
    .dividend (dvd_mag),
    .divisor  (dvs_mag),
    .quo_dvd  (quo_dvd),
    .divisor_q(divisor_q),
    .sub_taken(sub_taken)
  );

  div_sign_fix #(.W(W)) u_fix (
    .negate     (sign_q),
    .magnitude_q(quo_dvd),
    .result     (fixed_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      iter_left <= '0;
      sign_q    <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_RUN;
          iter_left <= LAST_ITER;
          sign_q    <= neg_now;
        end
        ST_RUN: begin
          if (iter_left == '0) state <= ST_FIX;
          else                 iter_left <= iter_left - 1'b1;
        end
        ST_FIX: begin
          state    <= ST_IDLE;
          quotient <= fixed_q;
          done     <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // busy-cycle counter that watches the latency window
  logic [LW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (accept)  run_len <= '0;
    else if (busy)    run_len <= run_len + 1'b1;
  end

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == LW'(W + 1)));
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_quotient_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(quotient)));
  a_r9_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(divisor_q) && $stable(sign_q)));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    iterate |=> (quo_dvd[0] == $past(sub_taken)));
endmodule

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int DW = 8;
  localparam logic [DW-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [5:0]    opx = 6'h24;
  logic [DW-1:0] a = '0, b = '0;
  logic          busy, done;
  logic [DW-1:0] quotient;

  int n_checks = 0;
  int n_fail = 0;

  always #2ns clk = ~clk;  // 250 MHz

  seq_divider #(.W(DW)) i_seq_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .opx(opx),
    .a(a), .b(b), .busy(busy), .done(done), .quotient(quotient)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference quotient, computed with integer arithmetic
  function automatic logic [DW-1:0] ref_q(input bit sg, input logic [DW-1:0] x, input logic [DW-1:0] y);
    int sx, sy;
    if (!sg) return (y == 0) ? ONES : DW'(int'(x) / int'(y));
    sx = int'($signed(x));
    sy = int'($signed(y));
    if (sy == 0) return (sx < 0) ? DW'(1) : ONES;
    return DW'(sx / sy);
  endfunction

  // called at a falling edge while the block is idle or finishing; returns at the done cycle
  task automatic do_op(input logic [5:0] op, input logic [DW-1:0] x, input logic [DW-1:0] y,
                       input logic [DW-1:0] exp, input string req);
    start = 1'b1; opx = op; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    repeat (DW) @(negedge clk);
    @(negedge clk);
    check(done === 1'b1 && quotient === exp, req, {done, quotient}, {1'b1, exp});
  endtask

  initial begin
    #(200000 * 4ns);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy === 1'b0 && done === 1'b0 && quotient === '0, "R11", {busy, done, quotient}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R11", {busy, done}, 0);

    // R7: busy for W+1 cycles, done at edge W+1
    begin
      bit ok = 1'b1;
      start = 1'b1; opx = 6'h24; a = 8'd200; b = 8'd9;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < DW; k++) begin
        if (!(busy === 1'b1 && done === 1'b0)) ok = 1'b0;
        @(negedge clk);
      end
      if (!(busy === 1'b1 && done === 1'b0)) ok = 1'b0;
      @(negedge clk);
      check(ok && done === 1'b1 && busy === 1'b0, "R7", {ok, done, busy}, 3'b110);
      check(quotient === 8'd22, "R2", quotient, 22);
      @(negedge clk);
      // R8: done lasts a single cycle and the result holds
      check(done === 1'b0, "R8", done, 0);
      repeat (5) @(negedge clk);
      check(quotient === 8'd22, "R8", quotient, 22);
    end

    // R9: start during a run is ignored
    start = 1'b1; opx = 6'h24; a = 8'd100; b = 8'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; opx = 6'h25; a = 8'd1; b = 8'd1;
    @(negedge clk);
    start = 1'b0;
    repeat (DW - 4) @(negedge clk);
    @(negedge clk);
    check(done === 1'b1 && quotient === 8'd14, "R9", {done, quotient}, {1'b1, 8'd14});
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R9", {busy, done}, 0);

    // R1: a code other than 0x25 divides unsigned
    do_op(6'h3F, 8'hF0, 8'h02, 8'h78, "R1");
    do_op(6'h25, 8'hF0, 8'h02, 8'hF8, "R1");
    // R6: most negative dividend
    do_op(6'h25, 8'h80, 8'hFF, 8'h80, "R6");
    do_op(6'h25, 8'h80, 8'h01, 8'h80, "R6");
    do_op(6'h25, 8'h80, 8'h02, 8'hC0, "R6");
    // R5: zero divisor
    do_op(6'h24, 8'h37, 8'h00, 8'hFF, "R5");
    do_op(6'h25, 8'h90, 8'h00, 8'h01, "R5");
    do_op(6'h25, 8'h10, 8'h00, 8'hFF, "R5");
    // R4: every bit of the quotient produced
    do_op(6'h24, 8'hFF, 8'h01, 8'hFF, "R4");
    do_op(6'h24, 8'hA5, 8'hFF, 8'h00, "R4");
    do_op(6'h24, 8'hFF, 8'hFF, 8'h01, "R4");

    // R2/R3/R10: back-to-back sweep; each next start lands in the done cycle
    for (int sg = 0; sg < 2; sg++) begin
      for (int ai = 0; ai < 256; ai++) begin
        for (int bi = 0; bi < 256; bi += 13) begin
          logic [DW-1:0] x = DW'(ai);
          logic [DW-1:0] y = DW'(bi);
          string tag = (bi == 0) ? "R5" : ((sg == 1) ? "R3 R10" : "R2 R10");
          do_op(sg ? 6'h25 : 6'h24, x, y, ref_q(sg[0], x, y), tag);
        end
      end
    end
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R10", {busy, done}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule